// File: doc/BRIEF.md
# Oversampling UART Receive Engine

This block is the receive half of a PC-style asynchronous serial port. It watches the serial input line and a clock-enable pulse that arrives at sixteen times the bit rate, typically produced by a programmable baud divisor elsewhere. It finds the falling edge of a start bit and confirms it halfway through the bit. It then samples each following bit near its centre and builds a character of 5 to 8 bits. An optional parity bit and one or two stop bits follow the data.

The finished character is placed in a receive holding register, and a data-ready flag goes high. A sticky set of line-status flags reports overrun, parity, framing and break conditions. Software-side logic clears the data-ready flag with a read strobe for the holding register, and clears the error flags with a read strobe for the line-status register. The line format comes from line-control inputs and is captured at each start edge, so a format change takes effect from the next character.

Top module: `uart_rx_engine`

## Requirements
- R1: The line idles at 1. A character starts when a tick finds the synchronized line at 0 and the previous tick sampled while hunting found it at 1.
- R2: Eight ticks after the start edge the line is checked again. If it reads 1, the character is abandoned without any output change and hunting resumes.
- R3: The first data bit is sampled 24 ticks after the start edge, and each later bit 16 ticks after the previous one. Data bits arrive least significant first, and bit i of the character lands in rx_data[i].
- R4: The word length code wlen_sel selects the data bits: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Unused upper bits of rx_data read 0.
- R5: With par_en = 1 and par_stick = 0, one parity bit follows the data. par_even = 1 expects an even count of ones over the data and parity bits together; par_even = 0 expects an odd count. A mismatch sets parity_err.
- R6: With par_en = 1 and par_stick = 1, the expected parity bit is the inverse of par_even: 0 when par_even = 1, and 1 when par_even = 0.
- R7: data_ready rises on the cycle after a character completes, and a new rx_data value appears on that same cycle. rbr_rd clears data_ready. A completion in the same cycle as rbr_rd leaves data_ready set. rx_data changes only on a completion.
- R8: If a character completes while data_ready is set and rbr_rd is not asserted, overrun_err is set and the new character replaces the old one.
- R9: framing_err is set when a sampled stop bit reads 0. With two_stop = 1, both stop bits are sampled.
- R10: If every sample of a character reads 0 (start check, data, parity and stops), break_det and framing_err are set and one character of value 0 is delivered. No further character starts until the line has returned to 1.
- R11: overrun_err, parity_err, framing_err and break_det stay set until lsr_rd. A new error in the same cycle as lsr_rd wins over the clear.
- R12: After reset, every output is 0 and the receiver is hunting with the line taken as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, asynchronous |
| wlen_sel | input | 2 | Word length code |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| rbr_rd | input | 1 | Holding register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Unread character present |
| overrun_err | output | 1 | Character lost to overrun |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop bit read as 0 |
| break_det | output | 1 | Break condition seen |

## Verification
A behavioural reference model runs the same line and strobes, and the bench compares every output against it on every clock. The stimulus also covers several specific cases. Frames are sent at all four word lengths with patterns whose upper bits are set, which shows that truncation and bit order are right. Parity frames are sent both correct and deliberately wrong under even, odd and stick selection. For data 0x01, the stick-even setting expects the opposite bit from plain even parity, so a design that ignores the stick select fails there. A short low glitch, a long low break, a bad stop bit (once with one stop bit and once in the second of two), back-to-back unread frames and interleaved read strobes each exercise one of the flag rules.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam int unsigned IDX_W  = 4;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } urx_state_e;

  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_PAR  = 2'd1,
    K_STOP = 2'd2
  } urx_kind_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } urx_fmt_t;

  function automatic logic [IDX_W-1:0] word_bits(input logic [1:0] code);
    return IDX_W'(5) + {{(IDX_W-2){1'b0}}, code};
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/urx_frame_ctrl.sv
module urx_frame_ctrl
  import urx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxs,
  input  urx_fmt_t         fmt_in,
  output urx_fmt_t         fmt_q,
  output logic             samp_vld,
  output urx_kind_e        samp_kind,
  output logic [IDX_W-1:0] samp_idx,
  output logic             frame_start,
  output logic             frame_done
);

  localparam int unsigned MID   = OSR / 2;
  localparam int unsigned FIRST = OSR + MID;
  localparam int unsigned CW    = $clog2(FIRST);

  urx_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             prev_q, prev_d;
  urx_fmt_t         fmt_d;
  logic [IDX_W-1:0] wl;
  logic [IDX_W-1:0] last_idx;
  logic             take;

  always_comb begin
    wl       = word_bits(fmt_q.wlen);
    last_idx = wl + {{(IDX_W-1){1'b0}}, fmt_q.par_en}
                  + {{(IDX_W-1){1'b0}}, fmt_q.two_stop};
    if (idx_q < wl)                    samp_kind = K_DATA;
    else if (idx_q == wl && fmt_q.par_en) samp_kind = K_PAR;
    else                               samp_kind = K_STOP;
  end

  assign samp_idx = idx_q;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    prev_d      = prev_q;
    fmt_d       = fmt_q;
    take        = 1'b0;
    frame_start = 1'b0;
    frame_done  = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_HUNT: begin
          prev_d = rxs;
          if (prev_q && !rxs) begin
            state_d     = ST_START;
            cnt_d       = '0;
            idx_d       = '0;
            fmt_d       = fmt_in;
            frame_start = 1'b1;
          end
        end
        ST_START: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(MID - 1) && rxs) begin
            state_d = ST_HUNT;
            prev_d  = 1'b1;
          end else if (cnt_q == CW'(FIRST - 1)) begin
            take = 1'b1;
          end
        end
        ST_BITS: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(OSR - 1)) take = 1'b1;
        end
        default: state_d = ST_HUNT;
      endcase
      if (take) begin
        cnt_d = '0;
        if (idx_q == last_idx) begin
          frame_done = 1'b1;
          state_d    = ST_HUNT;
          prev_d     = rxs;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_BITS;
        end
      end
    end
  end

  assign samp_vld = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b1;
      fmt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      prev_q  <= prev_d;
      fmt_q   <= fmt_d;
    end
  end

endmodule

// File: rtl/urx_char_build.sv
module urx_char_build
  import urx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs,
  input  logic              frame_start,
  input  logic              samp_vld,
  input  urx_kind_e         samp_kind,
  input  logic [IDX_W-1:0]  samp_idx,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic [CHAR_W-1:0] char_val,
  output logic              char_pe,
  output logic              char_fe,
  output logic              char_bi
);

  logic [CHAR_W-1:0] data_q, data_d;
  logic              par_q, par_d;
  logic              stop_ok_q, stop_ok_d;
  logic              zero_q, zero_d;
  logic              exp_par;

  always_comb begin
    data_d    = data_q;
    par_d     = par_q;
    stop_ok_d = stop_ok_q;
    zero_d    = zero_q;
    if (frame_start) begin
      data_d    = '0;
      par_d     = 1'b0;
      stop_ok_d = 1'b1;
      zero_d    = 1'b1;
    end else if (samp_vld) begin
      zero_d = zero_q & ~rxs;
      unique case (samp_kind)
        K_DATA:  if (samp_idx < IDX_W'(CHAR_W)) data_d[samp_idx[2:0]] = rxs;
        K_PAR:   par_d = rxs;
        default: stop_ok_d = stop_ok_q & rxs;
      endcase
    end
  end

  always_comb begin
    if (par_stick)     exp_par = ~par_even;
    else if (par_even) exp_par = ^data_q;
    else               exp_par = ~(^data_q);
    char_val = data_q;
    char_pe  = par_en && (par_q != exp_par);
    char_fe  = !(stop_ok_q && rxs);
    char_bi  = zero_q && !rxs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      par_q     <= 1'b0;
      stop_ok_q <= 1'b1;
      zero_q    <= 1'b1;
    end else begin
      data_q    <= data_d;
      par_q     <= par_d;
      stop_ok_q <= stop_ok_d;
      zero_q    <= zero_d;
    end
  end

endmodule

// File: rtl/urx_status.sv
module urx_status
  import urx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [CHAR_W-1:0] char_val,
  input  logic              char_pe,
  input  logic              char_fe,
  input  logic              char_bi,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  output logic [CHAR_W-1:0] rbr_q,
  output logic              dr_q,
  output logic              oe_q,
  output logic              pe_q,
  output logic              fe_q,
  output logic              bi_q
);

  logic [CHAR_W-1:0] rbr_d;
  logic dr_d, oe_d, pe_d, fe_d, bi_d;
  logic ovr_set;

  always_comb begin
    ovr_set = frame_done && dr_q && !rbr_rd;
    rbr_d   = frame_done ? char_val : rbr_q;
    if (frame_done)  dr_d = 1'b1;
    else if (rbr_rd) dr_d = 1'b0;
    else             dr_d = dr_q;
    oe_d = (oe_q & ~lsr_rd) | ovr_set;
    pe_d = (pe_q & ~lsr_rd) | (frame_done & char_pe);
    fe_d = (fe_q & ~lsr_rd) | (frame_done & char_fe);
    bi_d = (bi_q & ~lsr_rd) | (frame_done & char_bi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      rbr_q <= rbr_d;
      dr_q  <= dr_d;
      oe_q  <= oe_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
      bi_q  <= bi_d;
    end
  end

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import urx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] wlen_sel,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det
);

  logic              rxs;
  urx_fmt_t          fmt_in, fmt_q;
  logic              samp_vld;
  urx_kind_e         samp_kind;
  logic [IDX_W-1:0]  samp_idx;
  logic              frame_start;
  logic              frame_done;
  logic [CHAR_W-1:0] char_val;
  logic              char_pe, char_fe, char_bi;

  assign fmt_in = '{wlen: wlen_sel, two_stop: two_stop, par_en: par_en,
                    par_even: par_even, par_stick: par_stick};

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (rxd), .dout (rxs)
  );

  urx_frame_ctrl #(.OSR(OSR)) u_ctrl (
    .clk (clk), .rst_n (rst_n), .tick (tick), .rxs (rxs),
    .fmt_in (fmt_in), .fmt_q (fmt_q),
    .samp_vld (samp_vld), .samp_kind (samp_kind), .samp_idx (samp_idx),
    .frame_start (frame_start), .frame_done (frame_done)
  );

  urx_char_build u_build (
    .clk (clk), .rst_n (rst_n), .rxs (rxs),
    .frame_start (frame_start), .samp_vld (samp_vld),
    .samp_kind (samp_kind), .samp_idx (samp_idx),
    .par_en (fmt_q.par_en), .par_even (fmt_q.par_even),
    .par_stick (fmt_q.par_stick),
    .char_val (char_val), .char_pe (char_pe),
    .char_fe (char_fe), .char_bi (char_bi)
  );

  urx_status u_stat (
    .clk (clk), .rst_n (rst_n), .frame_done (frame_done),
    .char_val (char_val), .char_pe (char_pe), .char_fe (char_fe),
    .char_bi (char_bi), .rbr_rd (rbr_rd), .lsr_rd (lsr_rd),
    .rbr_q (rx_data), .dr_q (data_ready), .oe_q (overrun_err),
    .pe_q (parity_err), .fe_q (framing_err), .bi_q (break_det)
  );

endmodule

// File: rtl/urx_checker.sv
module urx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rbr_rd,
  input logic       lsr_rd,
  input logic       frame_done,
  input logic [7:0] rx_data,
  input logic       data_ready,
  input logic       overrun_err,
  input logic       parity_err,
  input logic       framing_err,
  input logic       break_det
);

  // R3: a character only completes on a sample tick
  p_done_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tick);

  // R7: completion raises data-ready
  p_dr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> data_ready);

  // R7: a read with no completion clears data-ready
  p_dr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !frame_done) |=> !data_ready);

  // R7: held character only changes on completion
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data));

  // R8: completion over an unread character flags overrun
  p_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && data_ready && !rbr_rd) |=> overrun_err);

  // R10: a break is reported as a zero character with a framing error
  p_brk_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_det) |-> (rx_data == 8'h00 && framing_err));

  // R11: status read with no completion clears every error flag
  p_lsr_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !frame_done) |=> !(overrun_err || parity_err || framing_err || break_det));

  // R11: flags stay set without a status read
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_rd && (parity_err || framing_err)) |=> (parity_err || framing_err));

endmodule

bind uart_rx_engine urx_checker u_chk (
  .clk (clk), .rst_n (rst_n), .tick (tick), .rbr_rd (rbr_rd),
  .lsr_rd (lsr_rd), .frame_done (frame_done), .rx_data (rx_data),
  .data_ready (data_ready), .overrun_err (overrun_err),
  .parity_err (parity_err), .framing_err (framing_err),
  .break_det (break_det)
);

// File: tb/test_uart_rx_engine.sv
`timescale 1ns/1ps
module test_uart_rx_engine;

  localparam int DIV = 4;
  localparam int BP  = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] b_wlen = 2'b11;
  logic b_two = 1'b0, b_pen = 1'b0, b_even = 1'b0, b_stick = 1'b0;
  logic rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rx_data;
  logic data_ready, overrun_err, parity_err, framing_err, break_det;

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_engine i_uart_rx_engine (
    .clk (clk), .rst_n (rst_n), .tick (tick), .rxd (rxd),
    .wlen_sel (b_wlen), .two_stop (b_two), .par_en (b_pen),
    .par_even (b_even), .par_stick (b_stick),
    .rbr_rd (rbr_rd), .lsr_rd (lsr_rd),
    .rx_data (rx_data), .data_ready (data_ready),
    .overrun_err (overrun_err), .parity_err (parity_err),
    .framing_err (framing_err), .break_det (break_det)
  );

  // tick generator
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      tick = (c == DIV - 1);
      c = (c == DIV - 1) ? 0 : c + 1;
    end
  end

  // behavioural reference model
  logic m_s1, m_s2, m_prev;
  bit   m_busy;
  int   m_t, m_wl, m_nb;
  bit   m_pen, m_even, m_stick, m_two;
  bit   m_fb [0:15];
  logic [7:0] m_rbr;
  logic m_dr, m_oe, m_pe, m_fe, m_bi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_t = 0;
      m_wl = 8; m_nb = 9; m_pen = 0; m_even = 0; m_stick = 0; m_two = 0;
      m_rbr = 0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    end else begin
      logic cur;
      bit done, npe, nfe, nbi;
      logic [7:0] nch;
      done = 0; npe = 0; nfe = 0; nbi = 0; nch = 0;
      cur = m_s2; m_s2 = m_s1; m_s1 = rxd;
      if (tick) begin
        if (!m_busy) begin
          if (m_prev && !cur) begin
            m_busy = 1; m_t = 0;
            m_wl = 5 + int'(b_wlen); m_pen = b_pen; m_even = b_even;
            m_stick = b_stick; m_two = b_two;
            m_nb = m_wl + int'(m_pen) + 1 + int'(m_two);
          end
          m_prev = cur;
        end else begin
          m_t++;
          if (m_t == 8 && cur) begin
            m_busy = 0; m_prev = 1;
          end else if (m_t >= 24 && (m_t - 24) % 16 == 0) begin
            int k;
            k = (m_t - 24) / 16;
            m_fb[k] = cur;
            if (k == m_nb - 1) begin
              int ones;
              bit expb, allz;
              done = 1; m_busy = 0; m_prev = cur;
              ones = 0; allz = 1;
              for (int i = 0; i < m_wl; i++) begin
                nch[i] = m_fb[i]; ones += int'(m_fb[i]);
              end
              for (int i = 0; i < m_nb; i++) if (m_fb[i]) allz = 0;
              if (m_stick) expb = !m_even;
              else if (m_even) expb = (ones % 2) == 1;
              else expb = (ones % 2) == 0;
              npe = m_pen && (m_fb[m_wl] != expb);
              for (int i = m_wl + int'(m_pen); i < m_nb; i++) if (!m_fb[i]) nfe = 1;
              nbi = allz;
            end
          end
        end
      end
      m_oe = (m_oe & !lsr_rd) | (done && m_dr && !rbr_rd);
      m_pe = (m_pe & !lsr_rd) | (done && npe);
      m_fe = (m_fe & !lsr_rd) | (done && nfe);
      m_bi = (m_bi & !lsr_rd) | (done && nbi);
      if (done) begin m_dr = 1; m_rbr = nch; end
      else if (rbr_rd) m_dr = 0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R3 R4 rx_data vs model", rx_data, m_rbr);
      chk("R7 data_ready vs model", {7'b0, data_ready}, {7'b0, m_dr});
      chk("R8 overrun_err vs model", {7'b0, overrun_err}, {7'b0, m_oe});
      chk("R5 R6 parity_err vs model", {7'b0, parity_err}, {7'b0, m_pe});
      chk("R9 framing_err vs model", {7'b0, framing_err}, {7'b0, m_fe});
      chk("R10 break_det vs model", {7'b0, break_det}, {7'b0, m_bi});
    end
  end

  task automatic tx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [15:0] v;
    int n, wl, ones, nstop;
    bit p;
    v = '0; n = 1; ones = 0;
    wl = 5 + int'(b_wlen);
    for (int i = 0; i < wl; i++) begin
      v[n] = d[i]; ones += int'(d[i]); n++;
    end
    if (b_pen) begin
      if (b_stick) p = !b_even;
      else if (b_even) p = (ones % 2) == 1;
      else p = (ones % 2) == 0;
      v[n] = p ^ bad_par; n++;
    end
    nstop = b_two ? 2 : 1;
    for (int i = 0; i < nstop; i++) begin
      v[n] = (bad_stop && i == nstop - 1) ? 1'b0 : 1'b1; n++;
    end
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat (BP) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * BP) @(negedge clk);
  endtask

  task automatic rd_rbr();
    rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0; @(negedge clk);
  endtask

  task automatic rd_lsr();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0; @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] w, input bit two, input bit pen,
                         input bit ev, input bit st);
    b_wlen = w; b_two = two; b_pen = pen; b_even = ev; b_stick = st;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12 rx_data after reset", rx_data, 8'h00);
    chk("R12 flags after reset",
        {3'b0, data_ready, overrun_err, parity_err, framing_err, break_det}, 8'h00);
    run_cmp = 1'b1;
    repeat (3 * BP) @(negedge clk);

    // R1 R3: 8-bit, no parity
    set_fmt(2'b11, 0, 0, 0, 0);
    tx(8'hA5, 0, 0);
    chk("R3 byte 0xA5", rx_data, 8'hA5);
    chk("R7 data_ready set", {7'b0, data_ready}, 8'h01);
    rd_rbr();
    chk("R7 data_ready cleared by read", {7'b0, data_ready}, 8'h00);
    tx(8'h3C, 0, 0);
    chk("R1 byte 0x3C", rx_data, 8'h3C);
    rd_rbr();

    // R4: word lengths
    set_fmt(2'b00, 0, 0, 0, 0); tx(8'hFF, 0, 0);
    chk("R4 5-bit word", rx_data, 8'h1F); rd_rbr();
    set_fmt(2'b01, 0, 0, 0, 0); tx(8'hC3, 0, 0);
    chk("R4 6-bit word", rx_data, 8'h03); rd_rbr();
    set_fmt(2'b10, 0, 0, 0, 0); tx(8'hFF, 0, 0);
    chk("R4 7-bit word", rx_data, 8'h7F); rd_rbr();

    // R5: even and odd parity
    set_fmt(2'b11, 0, 1, 1, 0); tx(8'h07, 0, 0);
    chk("R5 even parity good", {7'b0, parity_err}, 8'h00); rd_rbr();
    tx(8'h07, 1, 0);
    chk("R5 even parity bad", {7'b0, parity_err}, 8'h01); rd_rbr();
    // R11: sticky across a good frame
    tx(8'h07, 0, 0);
    chk("R11 parity flag held", {7'b0, parity_err}, 8'h01); rd_rbr();
    rd_lsr();
    chk("R11 parity flag cleared by status read", {7'b0, parity_err}, 8'h00);
    set_fmt(2'b11, 0, 1, 0, 0); tx(8'h07, 0, 0);
    chk("R5 odd parity good", {7'b0, parity_err}, 8'h00); rd_rbr();
    tx(8'h07, 1, 0);
    chk("R5 odd parity bad", {7'b0, parity_err}, 8'h01); rd_rbr(); rd_lsr();

    // R6: stick parity; 0x01 with stick-even expects parity bit 0
    set_fmt(2'b11, 0, 1, 1, 1); tx(8'h01, 0, 0);
    chk("R6 stick even good", {7'b0, parity_err}, 8'h00); rd_rbr();
    tx(8'h01, 1, 0);
    chk("R6 stick even bad", {7'b0, parity_err}, 8'h01); rd_rbr(); rd_lsr();
    set_fmt(2'b10, 0, 1, 0, 1); tx(8'h55, 0, 0);
    chk("R6 stick odd good", {7'b0, parity_err}, 8'h00); rd_rbr();

    // R9: framing errors
    set_fmt(2'b11, 0, 0, 0, 0); tx(8'h81, 0, 1);
    chk("R9 bad stop", {7'b0, framing_err}, 8'h01);
    chk("R9 data still delivered", rx_data, 8'h81); rd_rbr(); rd_lsr();
    set_fmt(2'b11, 1, 0, 0, 0); tx(8'h42, 0, 1);
    chk("R9 bad second stop", {7'b0, framing_err}, 8'h01); rd_rbr(); rd_lsr();
    tx(8'h42, 0, 0);
    chk("R9 two good stops", {7'b0, framing_err}, 8'h00); rd_rbr();

    // R10: break
    set_fmt(2'b11, 0, 0, 0, 0);
    rxd = 1'b0; repeat (14 * BP) @(negedge clk);
    chk("R10 break flag", {7'b0, break_det}, 8'h01);
    chk("R10 break char zero", rx_data, 8'h00);
    rd_rbr();
    repeat (4 * BP) @(negedge clk);
    chk("R10 single break char", {7'b0, data_ready}, 8'h00);
    rxd = 1'b1; repeat (3 * BP) @(negedge clk);
    rd_lsr();
    chk("R11 break cleared", {7'b0, break_det}, 8'h00);

    // R8: overrun
    tx(8'h11, 0, 0);
    tx(8'h22, 0, 0);
    chk("R8 overrun flag", {7'b0, overrun_err}, 8'h01);
    chk("R8 newest char kept", rx_data, 8'h22);
    rd_rbr(); rd_lsr();
    chk("R11 overrun cleared", {7'b0, overrun_err}, 8'h00);

    // R2: glitch rejected
    rxd = 1'b0; repeat (5 * DIV) @(negedge clk);
    rxd = 1'b1; repeat (3 * BP) @(negedge clk);
    chk("R2 glitch gives no char", {7'b0, data_ready}, 8'h00);
    chk("R2 glitch leaves data", rx_data, 8'h22);
    tx(8'h96, 0, 0);
    chk("R1 frame after glitch", rx_data, 8'h96);
    rd_rbr();

    repeat (BP) @(negedge clk);
    summary();
  end

endmodule